// File: doc/BRIEF.md
# Block-Scaled FP8 Row Dot-Product Engine

The engine computes one output element of a matrix-vector product from two streams. Weights arrive as bytes grouped in frames of 34: thirty-two 8-bit floating-point weights, then a 16-bit half-precision scale sent low byte first. Activations arrive as signed 16-bit integers, one per weight. Each weight is decoded and multiplied with its activation, and the product is added to a per-frame partial sum. When the second scale byte is accepted, the partial sum is multiplied by the scale and folded into the row total.

A start pulse does three things. It takes the row length in elements, takes the weight format (E4M3 or E5M2), and clears all state. The result is an exact two's-complement fixed-point number. No rounding happens at any stage, so a reference model can match the output bit for bit. A one-cycle done pulse marks the end of the row, and the result then stays unchanged until the next start. A row length that is zero or not a multiple of 32 raises an error flag instead.

Top module: `fp8_block_dot`

## Requirements
- R1: The weight stream is framed in 34-byte blocks. Positions 0 to 31 carry weights, position 32 is the scale low byte and position 33 is the scale high byte. Framing restarts at position 0 after position 33, and weight w of block b pairs with activation number 32·b + w.
- R2: A weight byte is accepted only in the same cycle as an activation. `byte_ready_o` at a weight position needs `act_valid_i`, and `act_ready_o` is high only at a weight position with `byte_valid_i`. Scale bytes are accepted without an activation. Both readies are low when idle and in a start cycle.
- R3: With `fmt_i`=0, weights are E4M3: sign at bit 7, exponent at bits 6:3 with bias 7, mantissa at bits 2:0. Exponent 0 means a subnormal worth mantissa/8·2^-6. Codes 0x7F and 0xFF count as zero.
- R4: With `fmt_i`=1, weights are E5M2: sign at bit 7, exponent at bits 6:2 with bias 15, mantissa at bits 1:0. Exponent 0 means a subnormal worth mantissa/4·2^-14. Any code with exponent 31 counts as zero.
- R5: The scale is IEEE half precision: sign at bit 15, exponent at bits 14:10 with bias 15, mantissa at bits 9:0, and subnormals when the exponent is 0. A scale with exponent 31 makes the whole block contribute zero.
- R6: `result_o` equals the sum over blocks of scale × (sum of the 32 weight×activation products). It is exact, two's complement, with 40 fractional bits.
- R7: `done_o` is high for exactly one cycle. That cycle follows the acceptance of byte 33 of the last block. `result_o` stays stable while the engine is idle until the next start.
- R8: A start with a row length of zero or not a multiple of 32 sets `err_o` from the next cycle until the next start. No bytes are accepted and `done_o` stays low.
- R9: A start pulse at any time, including mid-row or in the cycle done is high, clears the result and the framing position and begins a new row. Data offered in the start cycle is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new row, sampling len_i and fmt_i |
| fmt_i | input | 1 | Weight format: 0 = E4M3, 1 = E5M2 |
| len_i | input | LEN_W | Row length in elements |
| byte_i | input | 8 | Weight-stream byte |
| byte_valid_i | input | 1 | byte_i is valid |
| byte_ready_o | output | 1 | byte_i is accepted this cycle when valid |
| act_i | input | ACT_W | Signed activation |
| act_valid_i | input | 1 | act_i is valid |
| act_ready_o | output | 1 | act_i is accepted this cycle when valid |
| result_o | output | ACC_W | Row result, fixed point with 40 fractional bits |
| done_o | output | 1 | One-cycle row-complete pulse |
| err_o | output | 1 | Row length rejected |

## Verification
Two events can land on the same clock edge: the done pulse that closes one row and a start pulse that opens the next. The bench chains rows so that start is driven in the very cycle done is seen. It then expects done to drop, the result to clear and framing to begin again at weight position 0. A second collision comes from start arriving mid-row while bytes and activations are being offered. The reference model expects neither stream to be consumed in that cycle and the old partial sum to be discarded. Both cases are judged every cycle against the model's readies, done, error flag and result.

// File: rtl/fp8dot_pkg.sv
package fp8dot_pkg;
  localparam int BLK_ELEMS = 32;
  localparam int BLK_BYTES = 34;
  localparam int POS_W     = 6;
  localparam logic [POS_W-1:0] POS_LO   = POS_W'(BLK_ELEMS);
  localparam logic [POS_W-1:0] POS_HI   = POS_W'(BLK_BYTES - 1);
  localparam int SCALE_SIG_W = 11;
  localparam int SCALE_MAX_SH = 29;

  typedef enum logic {
    FMT_E4M3 = 1'b0,
    FMT_E5M2 = 1'b1
  } fp8_fmt_e;
endpackage

// File: rtl/fp8_weight_decode.sv
// Decodes one FP8 code into a signed fixed-point value with FRAC fraction bits.
module fp8_weight_decode #(
  parameter int EXP_W   = 4,
  parameter int MAN_W   = 3,
  parameter bit HAS_INF = 1'b0,
  parameter int FRAC    = 16,
  parameter int OUT_W   = 33
) (
  input  logic [7:0]             code_i,
  output logic signed [OUT_W-1:0] val_o
);
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int NORM_OFS = FRAC - BIAS - MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             special;
  logic [OUT_W-1:0] mag;

  assign exp_f = code_i[MAN_W +: EXP_W];
  assign man_f = code_i[MAN_W-1:0];

  generate
    if (HAS_INF) begin : g_inf
      assign special = &exp_f;
    end else begin : g_noinf
      assign special = (&exp_f) && (&man_f);
    end
  endgenerate

  always_comb begin
    int sh;
    if (exp_f == '0) begin
      sh  = 1 + NORM_OFS;
      mag = OUT_W'(man_f) << sh;
    end else begin
      sh  = int'(exp_f) + NORM_OFS;
      mag = OUT_W'({1'b1, man_f}) << sh;
    end
    if (special) val_o = '0;
    else if (code_i[7]) val_o = -$signed(mag);
    else val_o = $signed(mag);
  end
endmodule

// File: rtl/fp16_scale_apply.sv
// Multiplies a block partial by a half-precision scale, exact, 24 extra fraction bits.
module fp16_scale_apply
  import fp8dot_pkg::*;
#(
  parameter int P_W = 54,
  parameter int C_W = P_W + SCALE_SIG_W + SCALE_MAX_SH
) (
  input  logic                   rst_ni,
  input  logic signed [P_W-1:0]  part_i,
  input  logic [15:0]            scale_i,
  output logic signed [C_W-1:0]  contrib_o
);
  localparam int PR_W = P_W + SCALE_SIG_W + 1;

  logic [4:0]              exp_f;
  logic [9:0]              man_f;
  logic [SCALE_SIG_W-1:0]  sig;
  logic [4:0]              sh;
  logic signed [PR_W-1:0]  prod;
  logic signed [C_W-1:0]   mag;

  assign exp_f = scale_i[14:10];
  assign man_f = scale_i[9:0];
  assign sig   = (exp_f == '0) ? {1'b0, man_f} : {1'b1, man_f};
  assign sh    = (exp_f == '0) ? 5'd0 : exp_f - 5'd1;
  assign prod  = PR_W'(part_i) * PR_W'($signed({1'b0, sig}));
  assign mag   = C_W'(prod) <<< sh;

  always_comb begin
    if (exp_f == 5'h1F) contrib_o = '0;
    else if (scale_i[15]) contrib_o = -mag;
    else contrib_o = mag;
  end

  // R5: a non-finite scale must zero the block
  always_comb begin
    if (rst_ni && exp_f == 5'h1F) begin
      assert_scale_special_R5 : assert (contrib_o == '0);
    end
  end
endmodule

// File: rtl/fp8_block_parser.sv
// Byte framing, stream pairing, block counting and row status.
module fp8_block_parser
  import fp8dot_pkg::*;
#(
  parameter int LEN_W = 16,
  localparam int BLK_W = LEN_W - 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             byte_valid_i,
  input  logic             act_valid_i,
  output logic             byte_ready_o,
  output logic             act_ready_o,
  output logic             w_fire_o,
  output logic             lo_fire_o,
  output logic             hi_fire_o,
  output logic             busy_o,
  output logic             err_o,
  output logic             done_o
);
  logic [POS_W-1:0] pos_q;
  logic [BLK_W-1:0] blk_q, nblk_q;
  logic             busy_q, err_q, done_q;
  logic             is_w, byte_fire, last_blk, len_bad;

  assign len_bad      = (len_i[4:0] != '0) || (len_i == '0);
  assign is_w         = pos_q < POS_LO;
  assign byte_ready_o = busy_q && !start_i && (!is_w || act_valid_i);
  assign act_ready_o  = busy_q && !start_i && is_w && byte_valid_i;
  assign byte_fire    = byte_valid_i && byte_ready_o;
  assign w_fire_o     = byte_fire && is_w;
  assign lo_fire_o    = byte_fire && (pos_q == POS_LO);
  assign hi_fire_o    = byte_fire && (pos_q == POS_HI);
  assign last_blk     = hi_fire_o && (blk_q == nblk_q - BLK_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      blk_q  <= '0;
      nblk_q <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      pos_q  <= '0;
      blk_q  <= '0;
      nblk_q <= len_i[LEN_W-1:5];
      busy_q <= !len_bad;
      err_q  <= len_bad;
      done_q <= 1'b0;
    end else begin
      done_q <= last_blk;
      if (byte_fire) pos_q <= (pos_q == POS_HI) ? '0 : pos_q + POS_W'(1);
      if (hi_fire_o) blk_q <= blk_q + BLK_W'(1);
      if (last_blk)  busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;
  assign done_o = done_q;

  assert_pos_range_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= POS_HI);
  assert_pos_wrap_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_fire_o |=> pos_q == '0);
  assert_pair_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_fire_o |-> act_valid_i && act_ready_o);
  assert_done_pulse_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_err_excl_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !busy_q && !done_q && !byte_ready_o);
endmodule

// File: rtl/fp8_block_dot.sv
module fp8_block_dot
  import fp8dot_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ACT_W  = 16,
  parameter int W_FRAC = 16,
  localparam int W_W   = W_FRAC + 17,
  localparam int P_W   = W_W + ACT_W + 5,
  localparam int C_W   = P_W + SCALE_SIG_W + SCALE_MAX_SH,
  localparam int ACC_W = C_W + LEN_W - 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             fmt_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic [ACT_W-1:0] act_i,
  input  logic             act_valid_i,
  output logic             act_ready_o,
  output logic [ACC_W-1:0] result_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int PROD_W = W_W + ACT_W;

  fp8_fmt_e                fmt_q;
  logic                    w_fire, lo_fire, hi_fire, busy;
  logic signed [W_W-1:0]   dec_val [2];
  logic signed [W_W-1:0]   w_val;
  logic signed [PROD_W-1:0] wprod;
  logic signed [P_W-1:0]   part_q;
  logic [7:0]              lo_q;
  logic signed [C_W-1:0]   contrib;
  logic signed [ACC_W-1:0] acc_q;

  fp8_block_parser #(.LEN_W(LEN_W)) i_parser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .len_i        (len_i),
    .byte_valid_i (byte_valid_i),
    .act_valid_i  (act_valid_i),
    .byte_ready_o (byte_ready_o),
    .act_ready_o  (act_ready_o),
    .w_fire_o     (w_fire),
    .lo_fire_o    (lo_fire),
    .hi_fire_o    (hi_fire),
    .busy_o       (busy),
    .err_o        (err_o),
    .done_o       (done_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_fmt
    localparam int EB = (g == 0) ? 4 : 5;
    localparam int MB = (g == 0) ? 3 : 2;
    fp8_weight_decode #(
      .EXP_W  (EB),
      .MAN_W  (MB),
      .HAS_INF(g == 1),
      .FRAC   (W_FRAC),
      .OUT_W  (W_W)
    ) i_dec (
      .code_i (byte_i),
      .val_o  (dec_val[g])
    );
  end

  assign w_val = dec_val[fmt_q];
  assign wprod = PROD_W'(w_val) * PROD_W'($signed(act_i));

  fp16_scale_apply #(.P_W(P_W), .C_W(C_W)) i_scale (
    .rst_ni    (rst_ni),
    .part_i    (part_q),
    .scale_i   ({byte_i, lo_q}),
    .contrib_o (contrib)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q  <= FMT_E4M3;
      part_q <= '0;
      lo_q   <= '0;
      acc_q  <= '0;
    end else if (start_i) begin
      fmt_q  <= fp8_fmt_e'(fmt_i);
      part_q <= '0;
      lo_q   <= '0;
      acc_q  <= '0;
    end else begin
      if (w_fire)  part_q <= part_q + P_W'(wprod);
      if (lo_fire) lo_q <= byte_i;
      if (hi_fire) begin
        acc_q  <= acc_q + ACC_W'(contrib);
        part_q <= '0;
      end
    end
  end

  assign result_o = acc_q;

  // Special weight codes must decode to zero
  always_comb begin
    if (rst_ni && w_fire && fmt_q == FMT_E4M3 && byte_i[6:0] == 7'h7F) begin
      assert_e4m3_nan_zero_R3 : assert (w_val == '0);
    end
    if (rst_ni && w_fire && fmt_q == FMT_E5M2 && byte_i[6:2] == 5'h1F) begin
      assert_e5m2_special_zero_R4 : assert (w_val == '0);
    end
  end

  assert_hold_idle_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && !start_i |=> $stable(acc_q));
  assert_start_clear_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> acc_q == '0 && part_q == '0);
  assert_fold_only_hi_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_fire && !start_i |=> $stable(acc_q));
endmodule

// File: tb/test_fp8_block_dot.sv
`timescale 1ns/1ps
module test_fp8_block_dot;
  localparam int ACC_W = 105;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             fmt = 1'b0;
  logic [15:0]      len = '0;
  logic [7:0]       byte_d = '0;
  logic             byte_v = 1'b0;
  logic [15:0]      act_d = '0;
  logic             act_v = 1'b0;
  logic             byte_rdy, act_rdy, done, err;
  logic [ACC_W-1:0] result;

  int checks = 0;
  int fails = 0;
  string cur_tag = "R7";
  int vprob = 75;

  logic [7:0]  bq[$];
  logic [15:0] aq[$];

  bit m_busy = 0, m_err = 0, m_done = 0, m_fmt = 0;
  int m_pos = 0, m_nblk = 0, m_bcnt = 0;
  logic signed [127:0] m_part = '0, m_acc = '0;
  logic [7:0] m_lo = '0;

  always #2 clk = ~clk;

  fp8_block_dot i_fp8_block_dot (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fmt_i(fmt), .len_i(len),
    .byte_i(byte_d), .byte_valid_i(byte_v), .byte_ready_o(byte_rdy),
    .act_i(act_d), .act_valid_i(act_v), .act_ready_o(act_rdy),
    .result_o(result), .done_o(done), .err_o(err)
  );

  function automatic logic signed [127:0] ref_weight(bit f, logic [7:0] b);
    logic signed [127:0] mag;
    int e, m;
    if (!f) begin
      e = int'(b[6:3]); m = int'(b[2:0]);
      if (b[6:0] == 7'h7F) return '0;
      mag = (e == 0) ? (128'(m) <<< 7) : (128'(8 + m) <<< (e + 6));
    end else begin
      e = int'(b[6:2]); m = int'(b[1:0]);
      if (e == 31) return '0;
      mag = (e == 0) ? 128'(m) : (128'(4 + m) <<< (e - 1));
    end
    return b[7] ? -mag : mag;
  endfunction

  function automatic logic signed [127:0] ref_contrib(logic signed [127:0] p, logic [15:0] s);
    logic signed [127:0] mag;
    int e, m;
    e = int'(s[14:10]); m = int'(s[9:0]);
    if (e == 31) return '0;
    mag = (e == 0) ? p * 128'(m) : (p * 128'(1024 + m)) <<< (e - 1);
    return s[15] ? -mag : mag;
  endfunction

  // Reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_done = 0; m_pos = 0; m_acc = '0; m_part = '0;
    end else if (start) begin
      m_busy = (len[4:0] == 0) && (len != 0);
      m_err = !m_busy; m_done = 0; m_fmt = fmt; m_pos = 0; m_bcnt = 0;
      m_nblk = int'(len) / 32; m_acc = '0; m_part = '0; m_lo = '0;
    end else begin
      m_done = 0;
      if (m_busy && byte_v && (m_pos >= 32 || act_v)) begin
        if (m_pos < 32) begin
          m_part = m_part + ref_weight(m_fmt, byte_d) * 128'($signed(act_d));
          void'(aq.pop_front());
          m_pos++;
        end else if (m_pos == 32) begin
          m_lo = byte_d; m_pos++;
        end else begin
          m_acc = m_acc + ref_contrib(m_part, {byte_d, m_lo});
          m_part = '0; m_pos = 0; m_bcnt++;
          if (m_bcnt == m_nblk) begin m_busy = 0; m_done = 1; end
        end
        void'(bq.pop_front());
      end
    end
  end

  task automatic chk(string tag, string what, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic compare();
    bit ebr, ear;
    ebr = m_busy && !start && (m_pos >= 32 || act_v);
    ear = m_busy && !start && m_pos < 32 && byte_v;
    chk("R2", "byte_ready", 128'(byte_rdy), 128'(ebr));
    chk("R2", "act_ready", 128'(act_rdy), 128'(ear));
    chk("R7", "done", 128'(done), 128'(m_done));
    chk("R8", "err", 128'(err), 128'(m_err));
    chk(cur_tag, "result", 128'(result), 128'(m_acc[ACC_W-1:0]));
  endtask

  task automatic drive_valids();
    byte_v = (bq.size() > 0) && (($urandom % 100) < vprob);
    byte_d = (bq.size() > 0) ? bq[0] : 8'h00;
    act_v  = (aq.size() > 0) && (($urandom % 100) < vprob);
    act_d  = (aq.size() > 0) ? aq[0] : 16'h0000;
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
    start = 1'b0;
    drive_valids();
  endtask

  function automatic logic [7:0] pick_w(int mode);
    logic [7:0] e4s[6] = '{8'h7F, 8'hFF, 8'hFE, 8'h80, 8'h00, 8'h01};
    logic [7:0] e5s[6] = '{8'h7C, 8'hFC, 8'h7D, 8'hFF, 8'h7B, 8'h03};
    if (mode == 1 && $urandom % 2 == 0) return e4s[$urandom % 6];
    if (mode == 2 && $urandom % 2 == 0) return e5s[$urandom % 6];
    return 8'($urandom);
  endfunction

  function automatic logic [15:0] pick_s(int mode);
    logic [15:0] ss[10] = '{16'h0000, 16'h8000, 16'h0001, 16'h83FF, 16'h7C00,
                            16'h7E00, 16'h7BFF, 16'hFBFF, 16'h0400, 16'h3C00};
    if (mode == 1) return ss[$urandom % 10];
    if (mode == 2) return 16'($urandom);
    return {1'($urandom), 5'(10 + $urandom % 11), 10'($urandom)};
  endfunction

  // stop: 0 run until idle, 1 return at done (next row chains), 2 abort after 20 cycles
  task automatic row(bit f, int n, int wmode, int smode, string tag, bit chain, int stop);
    logic [15:0] s;
    int guard;
    if (!chain) begin @(negedge clk); compare(); end
    cur_tag = tag;
    bq.delete(); aq.delete();
    if (n % 32 == 0) begin
      for (int b = 0; b < n / 32; b++) begin
        for (int w = 0; w < 32; w++) begin
          bq.push_back(pick_w(wmode));
          aq.push_back(16'($urandom));
        end
        s = pick_s(smode);
        bq.push_back(s[7:0]);
        bq.push_back(s[15:8]);
      end
    end
    start = 1'b1; fmt = f; len = 16'(n);
    drive_valids();
    guard = 0;
    do begin
      cyc();
      guard++;
      if (stop == 1 && m_done) break;
      if (stop == 2 && guard >= 20) break;
    end while ((m_busy || m_done) && guard < 20000);
    if (stop == 0) repeat (3) cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();                       // R7 reset state: idle, no done, result zero
    rst_n = 1'b1;
    repeat (2) cyc();
    row(0, 32, 0, 0, "R3", 0, 0);    // E4M3 random codes, unit-range scales
    row(0, 64, 1, 0, "R3", 0, 0);    // E4M3 NaN codes 0x7F/0xFF weigh zero
    row(1, 64, 2, 0, "R4", 0, 0);    // E5M2 exponent-31 codes weigh zero
    row(1, 96, 0, 1, "R5", 0, 0);    // zero, subnormal, non-finite scales
    row(0, 96, 1, 1, "R5", 0, 0);
    vprob = 40;
    row(0, 128, 0, 2, "R1", 0, 0);   // framing under heavy stalls
    vprob = 95;
    row(1, 160, 0, 2, "R6", 0, 0);
    row(0, 40, 0, 0, "R8", 0, 0);    // length not a multiple of 32
    row(0, 0, 0, 0, "R8", 0, 0);     // zero length
    row(0, 64, 0, 0, "R9", 0, 2);    // abandoned mid-row
    row(1, 64, 0, 2, "R9", 0, 1);    // restart falls on the done cycle
    row(0, 32, 1, 1, "R9", 1, 1);
    row(1, 32, 2, 0, "R9", 1, 0);
    vprob = 70;
    for (int i = 0; i < 12; i++) row(1'($urandom), 32 * (1 + $urandom % 4), $urandom % 3, $urandom % 3, "R6", 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule